// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog built on a free-running binary counter. It is controlled through a small register bus that has two locations. The mode location can be written and read. It holds a run-enable bit, a 3-bit timeout select, and a routing bit. The routing bit sends a timeout either to an internal reset request or to an interrupt. The key location is write-only. Writing the clear key to it restarts the count. Writing the stop key to it completes a two-step shutdown.

The watchdog starts counting as soon as reset is released, with no action from software. Software keeps it quiet by writing the clear key before the selected counter bit is reached. To stop the watchdog, software first writes the mode location with the enable bit low, then writes the stop key. Writing the enable bit high restarts it in one step. A timeout produces a single-cycle pulse, after which the counter wraps to zero and keeps running.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the mode location reads 0x82: enable bit 7 = 1, timeout select bits 6:4 = 000, routing bit 1 = 1. The counter starts from zero and runs at once.
- R2: Timeout select value s places the timeout at counter bit T = BASE_BIT + 2*min(s,5). While the watchdog runs, a timeout fires every 2^(T+1) cycles after the counter was last zeroed.
- R3: Each timeout gives a pulse exactly one cycle long. The counter then wraps to zero and continues, so timeouts repeat.
- R4: With the routing bit at 1 a timeout pulses `rst_req`. With the routing bit at 0 it pulses `irq`. The two outputs are never high together.
- R5: Writing 0x4E to the key location (address 1) zeroes the counter, so the next timeout comes a full period later.
- R6: Writing 0xB1 to the key location while the enable bit is 0 stops the counter. After that no pulses appear, and the counter value is kept.
- R7: Writing 0xB1 while the enable bit is 1 is ignored, and the watchdog keeps running.
- R8: Clearing the enable bit without a following 0xB1 leaves the counter running, and timeouts still occur.
- R9: Writing the mode location (address 0) with bit 7 = 1 restarts a stopped watchdog. Counting resumes from the value that was kept.
- R10: Writing any key value other than 0x4E or 0xB1 has no effect on counting or on timeouts.
- R11: The mode location reads back bits 7, 6:4 and 1, with all other bits 0. The key location always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = mode location, 1 = key location |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the location selected by `reg_addr` |
| rst_req | output | 1 | One-cycle internal reset request on a timeout |
| irq | output | 1 | One-cycle interrupt on a timeout |

## Verification
The assertions assume that `reg_addr` and `reg_wdata` are meaningful only while `reg_wr` is high, and that a single write targets only one location per cycle. They also assume the selected period is at least two cycles long, so a pulse is always followed by a quiet cycle. The stimulus drives writes as single-cycle strobes away from the clock edge and leaves the strobe low between accesses. It uses a small BASE_BIT so that every select value, including the saturated ones, completes several periods within the run.

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter int        BASE_BIT = 15,
  parameter logic [7:0] CLR_KEY  = 8'h4E,
  parameter logic [7:0] STOP_KEY = 8'hB1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       rst_req,
  output logic       irq
);
  localparam int CNT_W = BASE_BIT + 11;

  logic             en_bit;
  logic [2:0]       sel;
  logic             route;
  logic             run_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;
  logic             mode_wr, key_wr, clr_wr, stop_wr, hit;
  int               tap;

  assign mode_wr = reg_wr && !reg_addr;
  assign key_wr  = reg_wr && reg_addr;
  assign clr_wr  = key_wr && (reg_wdata == CLR_KEY);
  assign stop_wr = key_wr && (reg_wdata == STOP_KEY) && !en_bit;

  assign tap  = BASE_BIT + 2 * int'((sel > 3'd5) ? 3'd5 : sel);
  assign mask = {CNT_W{1'b1}} >> (CNT_W - 1 - tap);
  assign hit  = run_q && ((cnt & mask) == mask) && !clr_wr;

  assign reg_rdata = reg_addr ? 8'h00 : {en_bit, sel, 2'b00, route, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_bit <= 1'b1;
      sel    <= 3'd0;
      route  <= 1'b1;
    end else if (mode_wr) begin
      en_bit <= reg_wdata[7];
      sel    <= reg_wdata[6:4];
      route  <= reg_wdata[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       run_q <= 1'b1;
    else if (mode_wr && reg_wdata[7]) run_q <= 1'b1;
    else if (stop_wr)                 run_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clr_wr) cnt <= '0;
    else if (hit)    cnt <= '0;
    else if (run_q)  cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
      irq     <= 1'b0;
    end else begin
      rst_req <= hit && route;
      irq     <= hit && !route;
    end
  end
endmodule

module wdog_keyed_chk #(
  parameter int CNT_W = 26
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_addr,
  input logic [7:0]       reg_wdata,
  input logic             rst_req,
  input logic             irq,
  input logic             en_bit,
  input logic             route,
  input logic             run_q,
  input logic [CNT_W-1:0] cnt
);
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && irq));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || irq) |=> !(rst_req || irq));

  a_r4_route_reset: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(route));

  a_r4_route_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !$past(route));

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr && reg_wdata == 8'h4E) |=> (cnt == '0));

  a_r6_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr && reg_wdata == 8'hB1 && !en_bit) |=> !run_q);

  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !(rst_req || irq));

  a_r7_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr && reg_wdata == 8'hB1 && en_bit && run_q) |=> run_q);

  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && reg_wdata[7]) |=> run_q);
endmodule

bind wdog_keyed wdog_keyed_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .rst_req(rst_req), .irq(irq), .en_bit(en_bit),
  .route(route), .run_q(run_q), .cnt(cnt)
);

// File: tb/wdog_keyed_bench.sv
module wdog_keyed_bench;
  localparam int BASE = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       rst_req, irq;

  int checks = 0;
  int errors = 0;
  int n_rst = 0;
  int n_irq = 0;

  longint m_cnt;
  bit     m_run, m_en, m_route;
  int     m_sel;
  bit     e_rst, e_irq;

  always #2 clk = ~clk;

  wdog_keyed #(.BASE_BIT(BASE)) u_wdog_keyed (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rst_req(rst_req), .irq(irq)
  );

  function automatic longint period_of(int s);
    int t;
    t = BASE + 2 * ((s > 5) ? 5 : s);
    return longint'(1) << (t + 1);
  endfunction

  // reference model, updated from the values present before each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_run = 1; m_en = 1; m_sel = 0; m_route = 1;
      e_rst = 0; e_irq = 0;
    end else begin
      bit clr, hit;
      clr = reg_wr && reg_addr && reg_wdata == 8'h4E;
      hit = m_run && !clr && ((m_cnt % period_of(m_sel)) == period_of(m_sel) - 1);
      e_rst = hit && m_route;
      e_irq = hit && !m_route;
      if (clr) m_cnt = 0;
      else if (hit) m_cnt = 0;
      else if (m_run) m_cnt = m_cnt + 1;
      if (reg_wr && !reg_addr && reg_wdata[7]) m_run = 1;
      else if (reg_wr && reg_addr && reg_wdata == 8'hB1 && !m_en) m_run = 0;
      if (reg_wr && !reg_addr) begin
        m_en = reg_wdata[7]; m_sel = int'(reg_wdata[6:4]); m_route = reg_wdata[1];
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] e_rd;
      e_rd = reg_addr ? 8'h00 : {m_en, 3'(m_sel), 2'b00, m_route, 1'b0};
      check(rst_req == e_rst, "R2 R3 R4 rst_req", rst_req, e_rst);
      check(irq == e_irq, "R2 R3 R4 irq", irq, e_irq);
      check(reg_rdata == e_rd, "R11 readback", reg_rdata, e_rd);
      if (rst_req) n_rst++;
      if (irq) n_irq++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit a, input logic [7:0] d);
    @(negedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = 8'h00;
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r0, i0;
    idle(3); #1; rst_n = 1'b1;
    @(negedge clk);
    check(reg_rdata == 8'h82, "R1 mode after reset", reg_rdata, 8'h82);
    reg_addr = 1'b1; #1;
    check(reg_rdata == 8'h00, "R11 key reads zero", reg_rdata, 8'h00);
    reg_addr = 1'b0;

    idle(40);
    check(n_rst >= 2, "R3 repeating reset pulses", n_rst, 2);

    r0 = n_rst;
    for (int k = 0; k < 12; k++) begin wr(1'b1, 8'h4E); idle(8); end
    check(n_rst == r0, "R5 clear key holds off timeout", n_rst, r0);

    r0 = n_rst;
    for (int k = 0; k < 8; k++) begin wr(1'b1, 8'h33); idle(6); end
    check(n_rst > r0, "R10 other key has no effect", n_rst, r0 + 1);

    wr(1'b0, 8'h80);
    r0 = n_rst; i0 = n_irq;
    idle(40);
    check(n_irq > i0 && n_rst == r0, "R4 interrupt routing", n_irq - i0, 2);

    wr(1'b0, 8'hA0); wr(1'b1, 8'h4E);
    i0 = n_irq; idle(600);
    check(n_irq - i0 == 2, "R2 select 2 period", n_irq - i0, 2);

    i0 = n_irq; wr(1'b1, 8'hB1); idle(300);
    check(n_irq > i0, "R7 stop key ignored while enabled", n_irq - i0, 1);

    wr(1'b0, 8'h00);
    i0 = n_irq; idle(40);
    check(n_irq > i0, "R8 enable cleared alone keeps running", n_irq - i0, 2);

    wr(1'b1, 8'hB1);
    i0 = n_irq; r0 = n_rst; idle(300);
    check(n_irq == i0 && n_rst == r0, "R6 stopped watchdog is quiet", n_irq - i0, 0);

    wr(1'b0, 8'h80);
    i0 = n_irq; idle(40);
    check(n_irq > i0, "R9 re-enable without key", n_irq - i0, 2);

    wr(1'b0, 8'hB2); wr(1'b1, 8'h4E);
    r0 = n_rst; idle(2100);
    check(n_rst - r0 == 2, "R2 select 3 period", n_rst - r0, 2);

    wr(1'b0, 8'hE2); wr(1'b1, 8'h4E);
    r0 = n_rst; idle(33000);
    check(n_rst - r0 == 2, "R2 select 6 saturates", n_rst - r0, 2);

    wr(1'b0, 8'hFF);
    @(negedge clk);
    check(reg_rdata == 8'hF2, "R11 reserved bits read zero", reg_rdata, 8'hF2);

    idle(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule